// File: doc/BRIEF.md
# Two-Plane Keyed Alpha Compositor

This block merges one graphics pixel and one video overlay pixel into a single RGB output pixel each clock. Both inputs arrive together as 32-bit words, with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. They enter through a valid/ready handshake, and the result leaves through a second valid/ready handshake that honours backpressure.

The compositor builds the picture in two layers. The bottom plane is first laid over a black background, with colour 0x000000. The top plane is then laid over that result. Which plane sits on top is programmable.

Each plane has its own settings:
- a blend mode;
- a colour-key mode;
- a global alpha value;
- a key colour;
- a key mask.

A keyed-out pixel is fully transparent, so the layer beneath it shows through. The settings are loaded through a small write strobe. The plane order is loaded through its own strobe. Settings are meant to be changed only while no pixel is in flight.

Top module: `dual_plane_compositor`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. The video plane is on top, both planes use blend none with keying disabled, the graphics key mask is 0xFFFFFF and the video key mask is 0x000000. Under these settings the output equals the video pixel's RGB.
- R2: A pulse on ord_we with ord_top different from ord_bottom puts ord_top on top. Plane code 0 is graphics and plane code 1 is video. A pulse with ord_top equal to ord_bottom is rejected, and the order stays as it was.
- R3: Blend mode code 0 (none) makes a plane's RGB replace the layer below it wherever the plane is not keyed out.
- R4: Blend mode code 1 (global) gives each channel as (a*p + (255-a)*b + 127)/255, using integer division. Here a is the plane's global alpha, p is the plane's channel and b is the channel of the layer below.
- R5: Blend mode code 2 (per-pixel) uses the same formula as R4, with a taken from bits 31:24 of the plane's own pixel.
- R6: Key mode code 2 compares the plane's own RGB against its key. When ((rgb XOR key) AND mask) is zero, the plane is transparent and the layer below passes unchanged.
- R7: Key mode code 1 makes the same comparison against the RGB of the layer below. For the bottom plane, that layer is black.
- R8: Key bits whose mask bit is 0 do not take part in the compare.
- R9: Blend code 3 acts as none, and key code 3 acts as disabled.
- R10: Each accepted pixel pair appears on the output two cycles after it is accepted when out_ready stays high. Results leave in acceptance order, with none lost or duplicated.
- R11: While out_valid is high and out_ready is low, out_valid and out_rgb hold steady. in_ready is high whenever out_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one plane's settings |
| cfg_plane | input | 1 | Plane written: 0 graphics, 1 video |
| cfg_blend | input | 2 | Blend mode: 0 none, 1 global, 2 per-pixel |
| cfg_keymode | input | 2 | Key mode: 0 off, 1 layer below, 2 own pixel |
| cfg_galpha | input | 8 | Global alpha |
| cfg_key | input | 24 | Key colour |
| cfg_mask | input | 24 | Key compare mask |
| ord_we | input | 1 | Write strobe for plane order |
| ord_top | input | 1 | Plane placed on top |
| ord_bottom | input | 1 | Plane placed on bottom |
| in_valid | input | 1 | Input pixel pair valid |
| in_ready | output | 1 | Input pixel pair accepted |
| gfx_px | input | 32 | Graphics pixel, ARGB8888 |
| vid_px | input | 32 | Video pixel, ARGB8888 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_rgb | output | 24 | Composited RGB888 pixel |

## Verification
The assertions assume that out_ready is driven to a known value from reset onward. The hold check also relies on settings not changing while a pixel is stalled in the output stage. To stay inside these assumptions, the stimulus writes settings and order only after every accepted pixel has left the block. It also holds in_valid low during those writes. The sweep walks the top plane, both blend modes and both key modes, including the out-of-range codes. Pixels are built so that some match the keys exactly and others differ only in masked-out bits. The out_ready pattern stalls the output repeatedly.

// File: rtl/dual_plane_compositor.sv
module dual_plane_compositor (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_plane,
  input  logic [1:0]  cfg_blend,
  input  logic [1:0]  cfg_keymode,
  input  logic [7:0]  cfg_galpha,
  input  logic [23:0] cfg_key,
  input  logic [23:0] cfg_mask,
  input  logic        ord_we,
  input  logic        ord_top,
  input  logic        ord_bottom,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] gfx_px,
  input  logic [31:0] vid_px,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_rgb
);
  localparam logic GFX = 1'b0;
  localparam logic VID = 1'b1;

  logic [1:0]  blend_m [2];
  logic [1:0]  key_m   [2];
  logic [7:0]  galpha  [2];
  logic [23:0] key_c   [2];
  logic [23:0] key_msk [2];
  logic        top_pl;

  logic        s1_v, s2_v;
  logic [31:0] s1_top;
  logic [23:0] s1_low;
  logic        s1_en, s2_en;

  function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] p,
                                      input logic [7:0] b);
    logic [16:0] acc;
    acc = 17'(a) * 17'(p) + 17'(8'd255 - a) * 17'(b) + 17'd127;
    return 8'(acc / 17'd255);
  endfunction

  function automatic logic [23:0] layer(input logic [31:0] px, input logic [23:0] below,
                                        input logic [1:0] bm, input logic [1:0] km,
                                        input logic [7:0] ga, input logic [23:0] key,
                                        input logic [23:0] msk);
    logic [23:0] cmp;
    logic        hit;
    logic [7:0]  a;
    cmp = (km == 2'd1) ? below : px[23:0];
    hit = (km == 2'd1 || km == 2'd2) && (((cmp ^ key) & msk) == 24'd0);
    a   = (bm == 2'd1) ? ga : px[31:24];
    if (hit)
      return below;
    else if (bm == 2'd1 || bm == 2'd2)
      return {mix8(a, px[23:16], below[23:16]),
              mix8(a, px[15:8],  below[15:8]),
              mix8(a, px[7:0],   below[7:0])};
    else
      return px[23:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        blend_m[i] <= 2'd0;
        key_m[i]   <= 2'd0;
        galpha[i]  <= 8'hFF;
        key_c[i]   <= 24'd0;
      end
      key_msk[GFX] <= 24'hFFFFFF;
      key_msk[VID] <= 24'h000000;
    end else if (cfg_we) begin
      blend_m[cfg_plane] <= cfg_blend;
      key_m[cfg_plane]   <= cfg_keymode;
      galpha[cfg_plane]  <= cfg_galpha;
      key_c[cfg_plane]   <= cfg_key;
      key_msk[cfg_plane] <= cfg_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      top_pl <= VID;
    else if (ord_we && (ord_top != ord_bottom))
      top_pl <= ord_top;
  end

  wire         bot_pl  = ~top_pl;
  wire  [31:0] bot_px  = (bot_pl == VID) ? vid_px : gfx_px;
  wire  [31:0] top_px  = (top_pl == VID) ? vid_px : gfx_px;
  wire  [23:0] low_rgb = layer(bot_px, 24'd0, blend_m[bot_pl], key_m[bot_pl],
                               galpha[bot_pl], key_c[bot_pl], key_msk[bot_pl]);
  wire  [23:0] fin_rgb = layer(s1_top, s1_low, blend_m[top_pl], key_m[top_pl],
                               galpha[top_pl], key_c[top_pl], key_msk[top_pl]);

  assign s2_en    = !s2_v || out_ready;
  assign s1_en    = !s1_v || s2_en;
  assign in_ready = s1_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_top <= 32'd0;
      s1_low <= 24'd0;
    end else if (s1_en) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_top <= top_px;
        s1_low <= low_rgb;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      out_rgb <= 24'd0;
    end else if (s2_en) begin
      s2_v <= s1_v;
      if (s1_v) out_rgb <= fin_rgb;
    end
  end

  assign out_valid = s2_v;

  // R2
  ord_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_we && ord_top == ord_bottom) |=> $stable(top_pl));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid);

  // R10
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));
endmodule

// File: tb/dual_plane_compositor_tb.sv
module dual_plane_compositor_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0, cfg_plane = 0;
  logic [1:0] cfg_blend = 0, cfg_keymode = 0;
  logic [7:0] cfg_galpha = 0;
  logic [23:0] cfg_key = 0, cfg_mask = 0;
  logic ord_we = 0, ord_top = 0, ord_bottom = 0;
  logic in_valid = 0, out_ready = 0;
  logic [31:0] gfx_px = 0, vid_px = 0;
  logic in_ready, out_valid;
  logic [23:0] out_rgb;

  always #4 clk = ~clk;

  dual_plane_compositor u_dut (.*);

  int checks = 0, failures = 0;
  int step_no = 0;

  logic [1:0]  m_bm [2];
  logic [1:0]  m_km [2];
  logic [7:0]  m_ga [2];
  logic [23:0] m_key [2];
  logic [23:0] m_msk [2];
  logic        m_top;

  logic [23:0] exp_q [$];
  int          stamp_q [$];

  function automatic logic [7:0] mix(input int a, input int p, input int b);
    return 8'((a * p + (255 - a) * b + 127) / 255);
  endfunction

  function automatic logic [23:0] lay(input logic [31:0] px, input logic [23:0] below, input int pl);
    logic [23:0] c;
    int a;
    c = (m_km[pl] == 1) ? below : px[23:0];
    if ((m_km[pl] == 1 || m_km[pl] == 2) && (((c ^ m_key[pl]) & m_msk[pl]) == 0))
      return below;
    if (m_bm[pl] == 1 || m_bm[pl] == 2) begin
      a = (m_bm[pl] == 1) ? int'(m_ga[pl]) : int'(px[31:24]);
      return {mix(a, px[23:16], below[23:16]), mix(a, px[15:8], below[15:8]),
              mix(a, px[7:0], below[7:0])};
    end
    return px[23:0];
  endfunction

  function automatic logic [23:0] model(input logic [31:0] g, input logic [31:0] v);
    logic [23:0] low;
    int bp;
    bp  = m_top ? 0 : 1;
    low = lay(bp ? v : g, 24'd0, bp);
    return lay(m_top ? v : g, low, int'(m_top));
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_plane(input int pl, input int bm, input int km, input int ga,
                           input logic [23:0] key, input logic [23:0] msk);
    @(negedge clk);
    cfg_we = 1; cfg_plane = pl[0]; cfg_blend = bm[1:0]; cfg_keymode = km[1:0];
    cfg_galpha = ga[7:0]; cfg_key = key; cfg_mask = msk;
    m_bm[pl] = bm[1:0]; m_km[pl] = km[1:0]; m_ga[pl] = ga[7:0];
    m_key[pl] = key; m_msk[pl] = msk;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_order(input logic top, input logic bot);
    @(negedge clk);
    ord_we = 1; ord_top = top; ord_bottom = bot;
    if (top != bot) m_top = top;
    @(negedge clk);
    ord_we = 0;
  endtask

  // one pixel pair generator; some pairs hit keys exactly or in masked-out bits
  function automatic logic [31:0] mkpx(input int i, input int pl, input int salt);
    logic [31:0] h;
    h = 32'(i * 32'h9E3779B1 + salt * 32'h85EBCA6B + pl * 32'h27D4EB2F);
    h = h ^ (h >> 13);
    if (i % 4 == 1) return {h[31:24], m_key[pl] ^ (h[23:0] & ~m_msk[pl])};
    if (i % 4 == 2) return {h[31:24], m_key[1 - pl]};
    return h;
  endfunction

  task automatic stream(input string tag, input int n, input int salt, input int rdy_mode, input bit lat_chk);
    int sent = 0;
    logic hold_pend = 0;
    logic [23:0] held = 0;
    while (sent < n || exp_q.size() != 0) begin
      @(negedge clk);
      step_no++;
      case (rdy_mode)
        0: out_ready = 1;
        1: out_ready = (step_no % 3) != 0;
        default: out_ready = (step_no % 5) < 2;
      endcase
      if (sent < n) begin
        in_valid = 1;
        gfx_px = mkpx(sent, 0, salt);
        vid_px = mkpx(sent, 1, salt);
      end else in_valid = 0;
      #1;
      if (hold_pend)
        check("R11 hold", out_valid && out_rgb == held, {7'd0, out_valid, out_rgb}, {8'd1, held});
      hold_pend = out_valid && !out_ready;
      held = out_rgb;
      if (out_ready)
        check("R11 in_ready", in_ready, {31'd0, in_ready}, 32'd1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check({tag, " R10 extra"}, 0, {8'd0, out_rgb}, 32'd0);
        else begin
          logic [23:0] e;
          int st;
          e = exp_q.pop_front();
          st = stamp_q.pop_front();
          check(tag, out_rgb == e, {8'd0, out_rgb}, {8'd0, e});
          if (lat_chk) check("R10 latency", (step_no - st) == 2, step_no - st, 2);
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(gfx_px, vid_px));
        stamp_q.push_back(step_no);
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 0;
    out_ready = 0;
  endtask

  bit done = 0;
  initial begin
    #(8 * 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_bm[p] = 0; m_km[p] = 0; m_ga[p] = 8'hFF; m_key[p] = 0;
    end
    m_msk[0] = 24'hFFFFFF;
    m_msk[1] = 24'h000000;
    m_top = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1 out_valid", out_valid == 0, {31'd0, out_valid}, 0);
    check("R1 in_ready", in_ready == 1, {31'd0, in_ready}, 1);
    stream("R1 defaults", 12, 1, 0, 1);

    // R2 order change and rejection
    set_order(1'b0, 1'b1);
    stream("R2 gfx top", 10, 2, 1, 0);
    set_order(1'b1, 1'b1);
    stream("R2 reject", 10, 3, 0, 1);

    // R8 masked compare on graphics, own key
    set_plane(0, 0, 2, 255, 24'h123456, 24'hF0F0F0);
    stream("R8 mask", 12, 4, 2, 0);

    // R3 R4 R5 R6 R7 R9 sweep
    for (int t = 0; t < 2; t++)
      for (int tb = 0; tb < 4; tb++)
        for (int tk = 0; tk < 4; tk++)
          for (int bb = 0; bb < 3; bb++)
            for (int bk = 0; bk < 3; bk++) begin
              int tp, bp, cnt;
              tp = t; bp = 1 - t;
              cnt = t * 144 + tb * 36 + tk * 9 + bb * 3 + bk;
              set_order(tp[0], bp[0]);
              set_plane(tp, tb, tk, (cnt * 37) & 255, 24'(cnt * 24'h0A1B3), (cnt & 1) ? 24'hFFFFFF : 24'hF8FCF8);
              set_plane(bp, bb, bk, (cnt * 91 + 13) & 255, 24'(cnt * 24'h51C7), (cnt & 2) ? 24'hFFFFFF : 24'h00FF00);
              if (tb == 3 || tk == 3) stream("R9 codes", 8, cnt, cnt % 3, 0);
              else if (tk == 1 || bk == 1) stream("R7 below key", 8, cnt, cnt % 3, 0);
              else if (tk == 2 || bk == 2) stream("R6 own key", 8, cnt, cnt % 3, 0);
              else if (tb == 2) stream("R5 pixel alpha", 8, cnt, cnt % 3, 0);
              else if (tb == 1) stream("R4 global alpha", 8, cnt, cnt % 3, 0);
              else stream("R3 none", 8, cnt, cnt % 3, 0);
            end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule